// File: doc/BRIEF.md
# Three-Wire Half-Duplex Converter Host

This block is the host side of a link to a serial data-acquisition converter. The link has three wires: an active-low select, a serial clock, and one data line that both ends share. When the block sees a start request, it lowers select and waits a fixed settling time before it produces any clock edge. It then clocks a short configuration word out to the converter and stops driving the data line. After one clock period with nobody driving the line, it clocks in a 10-bit conversion result. It presents that result with a one-cycle done strobe.

The shared line is brought out as three pins: an output value, an output enable and an input value. The pad or board joins them into one wire. The settling wait is counted in system clocks and is derived from the clock frequency given in MHz. The serial clock comes from a divider. Requests that arrive while a frame is running, or during the rest time after it, are dropped.

Top module: `adc3w_host`

## Requirements
- R1: While reset is high and in the cycle after reset is released, cs_n is 1, sclk is 0, sdata_oe is 0, done is 0 and result is 0.
- R2: When start is 1 in a cycle where the block is idle, cs_n goes to 0 in the next cycle. cfg_word is captured at that same clock edge.
- R3: cs_n stays low with sclk at 0 for CLK_MHZ*SETTLE_US cycles (8000 by default) before the first serial period begins. The first rising sclk edge follows SCLK_HALF cycles later.
- R4: Each serial period lasts 2*SCLK_HALF system cycles: sclk is low for the first half and high for the second. sclk is 0 whenever cs_n is 1.
- R5: For the first CMD_W serial periods, sdata_oe is 1. During those periods sdata_o carries the captured word, MSB first, one bit per period. sdata_o changes only when sclk falls.
- R6: The serial period after the last command bit is a turnaround slot. In that slot sdata_oe is 0 and no data is taken in.
- R7: In the next RES_W periods, sdata_i is sampled at each rising sclk edge and the bits are assembled MSB first.
- R8: At the falling sclk edge that closes the last result period, cs_n returns to 1, done pulses for one cycle, and result shows the assembled word in that same cycle. result holds its value until the next done.
- R9: start is ignored while cs_n is 0. It is also ignored for GAP_CYC cycles after cs_n rises. A start that is held high is accepted in the first cycle after that rest time.
- R10: Changes on cfg_word after the start has been accepted have no effect on the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion frame |
| cfg_word | input | CMD_W | Configuration word to send |
| result | output | RES_W | Last received conversion result |
| done | output | 1 | One-cycle strobe: result updated |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter |
| sdata_o | output | 1 | Value driven onto the shared data line |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| sdata_i | input | 1 | Value read from the shared data line |

## Verification
A wrong phase count or sequencer state shows up in the very next system cycle. It appears as a select, clock or drive-enable level that differs from the expected frame timeline, so the bench compares those pins against a timeline model on every clock. A bit counter that is off by one moves the turnaround slot and the select release by a whole serial period, and the pin comparison catches that within 2*SCLK_HALF cycles. A shift-register or sampling-edge fault leaves the pin timing intact but corrupts result. That fault becomes visible only when done pulses at the end of the frame, where the bench compares result against the word its converter model sent.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CMD,
        ST_TURN,
        ST_RES,
        ST_GAP
    } adc3w_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic int unsigned settle_cycles(int unsigned mhz, int unsigned usec);
        return mhz * usec;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc3w_sclk_gen.sv
module adc3w_sclk_gen
    import adc3w_pkg::*;
#(
    parameter int unsigned HALF = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output logic      sclk,
    output sclk_evt_t evt
);
    localparam int unsigned PH_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

    logic [PH_W-1:0] phase_q;
    logic            sclk_q;
    logic            term;

    assign term = run && (phase_q == PH_LAST);

    always_comb begin
        evt.rise = term && !sclk_q;
        evt.fall = term && sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
            sclk_q  <= 1'b0;
        end else if (term) begin
            phase_q <= '0;
            sclk_q  <= ~sclk_q;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign sclk = sclk_q;
endmodule

// File: rtl/adc3w_timer.sv
module adc3w_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc3w_host.sv
module adc3w_host
    import adc3w_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned SETTLE_US = 80,
    parameter int unsigned SCLK_HALF = 4,
    parameter int unsigned CMD_W     = 4,
    parameter int unsigned RES_W     = 10,
    parameter int unsigned GAP_CYC   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CMD_W-1:0] cfg_word,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             cs_n,
    output logic             sclk,
    output logic             sdata_o,
    output logic             sdata_oe,
    input  logic             sdata_i
);
    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
    localparam int unsigned TMR_W      = $clog2(umax(SETTLE_CYC, GAP_CYC) + 1);
    localparam int unsigned BIT_W      = $clog2(umax(CMD_W, RES_W) + 1);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LOAD    = TMR_W'(GAP_CYC - 1);
    localparam logic [BIT_W-1:0] CMD_LAST    = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] RES_LAST    = BIT_W'(RES_W - 1);

    adc3w_state_e     state_q;
    logic [CMD_W-1:0] cmd_sr;
    logic [RES_W-1:0] rx_sr;
    logic [RES_W-1:0] result_q;
    logic [BIT_W-1:0] bit_cnt;
    logic             done_q;
    logic             sclk_run;
    sclk_evt_t        evt;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             res_end;

    assign sclk_run = (state_q == ST_CMD) || (state_q == ST_TURN) || (state_q == ST_RES);
    assign res_end  = (state_q == ST_RES) && evt.fall && (bit_cnt == RES_LAST);

    adc3w_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk  (clk),
        .rst  (rst),
        .run  (sclk_run),
        .sclk (sclk),
        .evt  (evt)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = SETTLE_LOAD;
        if (state_q == ST_IDLE && start) begin
            tmr_load = 1'b1;
        end else if (res_end) begin
            tmr_load = 1'b1;
            tmr_val  = GAP_LOAD;
        end
    end

    adc3w_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_sr   <= '0;
            rx_sr    <= '0;
            result_q <= '0;
            bit_cnt  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_sr  <= cfg_word;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_zero) begin
                        bit_cnt <= '0;
                        state_q <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (evt.fall) begin
                        if (bit_cnt == CMD_LAST) begin
                            bit_cnt <= '0;
                            state_q <= ST_TURN;
                        end else begin
                            cmd_sr  <= cmd_sr << 1;
                            bit_cnt <= bit_cnt + BIT_W'(1);
                        end
                    end
                end
                ST_TURN: begin
                    if (evt.fall) begin
                        state_q <= ST_RES;
                    end
                end
                ST_RES: begin
                    if (evt.rise) begin
                        rx_sr <= {rx_sr[RES_W-2:0], sdata_i};
                    end
                    if (res_end) begin
                        result_q <= rx_sr;
                        done_q   <= 1'b1;
                        state_q  <= ST_GAP;
                    end else if (evt.fall) begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (tmr_zero) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n     = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign sdata_oe = (state_q == ST_CMD);
    assign sdata_o  = sdata_oe & cmd_sr[CMD_W-1];
    assign result   = result_q;
    assign done     = done_q;
endmodule

// File: rtl/adc3w_host_chk.sv
module adc3w_host_chk #(
    parameter int unsigned RES_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [RES_W-1:0] result,
    input logic             done,
    input logic             cs_n,
    input logic             sclk,
    input logic             sdata_o,
    input logic             sdata_oe
);
    p_sclk_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_oe_only_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        sdata_oe |-> !cs_n);

    p_data_change_low_r5: assert property (@(posedge clk) disable iff (rst)
        (sdata_oe && $past(sdata_oe) && (sdata_o != $past(sdata_o))) |-> !sclk);

    p_oe_release_low_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sdata_oe) |-> (!sclk && !cs_n));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_with_cs_rise_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    p_frame_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(start));
endmodule

bind adc3w_host adc3w_host_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .result   (result),
    .done     (done),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdata_o  (sdata_o),
    .sdata_oe (sdata_oe)
);

// File: tb/adc3w_host_tb.sv
module adc3w_host_tb;
    localparam int SETTLE = 100 * 80;
    localparam int H      = 4;
    localparam int P      = 2 * H;
    localparam int CW     = 4;
    localparam int RW     = 10;
    localparam int GAP    = 16;
    localparam int NPER   = CW + 1 + RW;
    localparam int K_END  = SETTLE + 1 + P * NPER;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] cfg_word = '0;
    logic [RW-1:0] result;
    logic          done, cs_n, sclk, sdata_o, sdata_oe;
    logic          sdata_i = 1'b0;

    int            checks = 0;
    int            fails = 0;
    int            k = -1;
    int            cyc = 0;
    logic [CW-1:0] cfg_lat = '0;
    logic [RW-1:0] conv_word = '0;
    logic [RW-1:0] word_lat = '0;
    logic [RW-1:0] exp_res = '0;

    always #5 clk = ~clk;

    adc3w_host u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_word(cfg_word),
        .result(result), .done(done), .cs_n(cs_n), .sclk(sclk),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at k=%0d: got %0h expected %0h", req, what, k, act, exp);
        end
    endtask

    task automatic compare_now();
        int s, p, w;
        logic e_cs, e_sclk, e_oe, e_sdo, e_done;
        string tag;
        e_cs = 1'b1; e_sclk = 1'b0; e_oe = 1'b0; e_sdo = 1'b0; e_done = 1'b0;
        tag = "R9";
        if (k >= 1 && k <= SETTLE) begin
            e_cs = 1'b0;
            tag = (k == 1) ? "R2" : "R3";
        end else if (k > SETTLE && k < K_END) begin
            s = k - SETTLE - 1; p = s / P; w = s % P;
            e_cs = 1'b0;
            e_sclk = (w >= H);
            e_oe = (p < CW);
            if (e_oe) e_sdo = cfg_lat[CW-1-p];
            tag = (p < CW) ? "R5" : ((p == CW) ? "R6" : "R7");
        end else if (k >= K_END) begin
            e_done = (k == K_END);
            tag = (k == K_END) ? "R8" : "R9";
        end
        chk(cs_n === e_cs, tag, "cs_n", cs_n, e_cs);
        chk(sclk === e_sclk, "R4", "sclk", sclk, e_sclk);
        chk(sdata_oe === e_oe, tag, "sdata_oe", sdata_oe, e_oe);
        if (e_oe) begin
            // R10: sent bit comes from the word latched at acceptance
            chk(sdata_o === e_sdo, (cfg_word != cfg_lat) ? "R10" : "R5", "sdata_o", sdata_o, e_sdo);
        end
        chk(done === e_done, "R8", "done", done, e_done);
        chk(result === exp_res, (k == K_END) ? "R7" : "R8", "result", result, exp_res);
    endtask

    task automatic step();
        int s, p, nk;
        s = k - SETTLE - 1;
        p = (s >= 0) ? s / P : -1;
        if (k > SETTLE && p > CW && p < NPER) sdata_i = word_lat[RW-1-(p-CW-1)];
        else sdata_i = cyc[0];
        if (k < 0) begin
            nk = start ? 1 : -1;
            if (start) begin
                cfg_lat = cfg_word;
                word_lat = conv_word;
            end
        end else begin
            nk = (k + 1 >= K_END + GAP) ? -1 : k + 1;
        end
        @(negedge clk);
        cyc++;
        k = nk;
        if (k == K_END) exp_res = word_lat;
        compare_now();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [RW-1:0] words [3];
        int fidx;
        words[0] = 10'h3FF; words[1] = 10'h000; words[2] = 10'h201;
        // R1: reset state
        repeat (3) @(negedge clk);
        compare_now();
        rst = 1'b0;
        step();
        for (int i = 0; i < 4; i++) step();

        // Frame A with start and cfg noise while busy (R9, R10)
        cfg_word = 4'b1010;
        conv_word = 10'h2D5;
        start = 1'b1;
        step();
        start = 1'b0;
        while (k >= 0) begin
            start = ((k % 997) == 3) || (k == K_END + 2) || (k == K_END + GAP - 1);
            cfg_word = CW'(k ^ (k >> 3));
            step();
        end
        start = 1'b0;
        for (int i = 0; i < 6; i++) step();

        // Start held high: back-to-back frames after the rest time (R9)
        fidx = 0;
        conv_word = words[0];
        cfg_word = 4'b0110;
        start = 1'b1;
        while (fidx < 3 || k >= 0) begin
            step();
            if (k == K_END) begin
                fidx++;
                if (fidx < 3) begin
                    conv_word = words[fidx];
                    cfg_word = ~cfg_word;
                end else begin
                    start = 1'b0;
                end
            end
        end
        for (int i = 0; i < 5; i++) step();
        report();
        $finish;
    end
endmodule